// File: doc/BRIEF.md
# JTAG Programming Pin-Sharing Controller

This block decides, cycle by cycle, whether a group of eight port pads carries the in-system-programming JTAG signals or ordinary general-purpose I/O. A single "JTAG active" condition is formed from four sources. The first is a flag that the non-volatile configuration is still blank. The second is a configuration choice that dedicates the pins to JTAG. The third is a live enable coming from user logic. The fourth is an enable bit that the host processor writes into a control register, which reset clears. While the condition holds, the mode, clock and data-in pads feed the internal programming port and the data-out pad is driven from it. Otherwise every pad is passed through to the general-purpose I/O logic.

Two further pads can report the flash program/erase engine's state in parallel: a ready/busy status and an error flag. They come on as a pair only after the programming port signals an extension command while JTAG is active. They go off when JTAG becomes inactive or on reset. Each status pad can be set to push-pull or open-drain drive, so that several devices can share a wired status line.

Mode state and status levels are registered on the system clock. Pad data then flows combinationally from that state.

Top module: `jtag_pin_mux`

## Requirements
- R1: The JTAG-active state becomes 1 one clock after any of `cfg_blank`, `cfg_dedicated`, `pld_jtag_en` or the host enable bit is 1. It becomes 0 one clock after all four are 0.
- R2: While JTAG is active, pads 0, 1 and 5 have output enable 0 and output 0. They are routed to `prog_tms`, `prog_tck` and `prog_tdi` respectively. Pad 6 drives `prog_tdo` with output enable 1.
- R3: While JTAG is inactive, every pad's output and output enable equal `gpio_out` and `gpio_oe` for that pad. `prog_tms` is 1, `prog_tck` is 0 and `prog_tdi` is 1.
- R4: `gpio_in` always equals `pad_in` on every pad.
- R5: A clock edge with `host_we`=1 loads bit 0 of `host_wdata` into the host enable bit. A reset edge clears that bit.
- R6: `ext_cmd`=1 at an edge where JTAG is already active turns the status extension on at that edge. `ext_cmd` given while JTAG is inactive is ignored, and pads 3 and 4 stay general-purpose I/O.
- R7: The status extension turns off at the same edge where JTAG becomes inactive, and on reset. It stays off when JTAG comes back until a new `ext_cmd` arrives.
- R8: With the extension on, the pad 3 status level is 0 one clock after `eng_busy`=1 and 1 otherwise. The pad 4 error level is 0 one clock after `eng_error`=1 and 1 otherwise. Both levels are 1 after reset.
- R9: A status pad with its drive-select input at 0 (push-pull) drives its level with output enable 1. With drive-select 1 (open-drain) it has output 0 and output enable equal to the inverted level.
- R10: Pads 2 and 7 are always general-purpose I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_blank | input | 1 | Non-volatile configuration still unprogrammed |
| cfg_dedicated | input | 1 | Configuration dedicates pins to JTAG |
| pld_jtag_en | input | 1 | Live JTAG enable from user logic |
| host_we | input | 1 | Host control register write strobe |
| host_wdata | input | 8 | Host write data; bit 0 is the JTAG enable |
| ext_cmd | input | 1 | Status-extension enable strobe from programming port |
| stat_od | input | 1 | Ready/busy pad drive select, 1 = open-drain |
| err_od | input | 1 | Error pad drive select, 1 = open-drain |
| eng_busy | input | 1 | Flash engine program/erase in progress |
| eng_error | input | 1 | Flash engine error |
| prog_tdo | input | 1 | Serial data out from programming port |
| prog_tms | output | 1 | Mode select to programming port |
| prog_tck | output | 1 | Test clock to programming port |
| prog_tdi | output | 1 | Serial data in to programming port |
| gpio_out | input | 8 | General-purpose output data per pad |
| gpio_oe | input | 8 | General-purpose output enable per pad |
| gpio_in | output | 8 | Pad input data to general-purpose logic |
| pad_in | input | 8 | Pad input level |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enable |

## Verification
A wrong JTAG-active state shows at once on pads 0, 1, 5 and 6. Their output enables and the programming-port inputs then disagree with the general-purpose controls in the cycle after the enable sources change. A stale extension state shows on pads 3 and 4 in the same cycle that JTAG drops or comes back without a new command. Wrong status levels or drive modes show as wrong output or output-enable on those pads one clock after the engine flags change.

// File: rtl/jpm_pkg.sv
package jpm_pkg;

  typedef struct packed {
    logic out;
    logic oe;
  } pin_drv_t;

  // Converts an active-high "ok" level into a pad drive for the selected mode.
  function automatic pin_drv_t status_drive(input logic level, input logic open_drain);
    pin_drv_t d;
    if (open_drain) begin
      d.out = 1'b0;
      d.oe  = ~level;
    end else begin
      d.out = level;
      d.oe  = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/jpm_mode_ctrl.sv
module jpm_mode_ctrl #(
  parameter int HOST_W      = 8,
  parameter int HOST_EN_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_blank,
  input  logic              cfg_dedicated,
  input  logic              pld_jtag_en,
  input  logic              host_we,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              ext_cmd,
  output logic              jtag_on_q,
  output logic              ext_on_q
);

  logic host_q;
  logic host_d;
  logic jon_d;
  logic ext_d;
  logic unused_wdata;

  assign unused_wdata = ^host_wdata;

  always_comb begin
    host_d = host_we ? host_wdata[HOST_EN_BIT] : host_q;
    jon_d  = cfg_blank | cfg_dedicated | pld_jtag_en | host_d;
    ext_d  = jon_d & (ext_on_q | (ext_cmd & jtag_on_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q    <= 1'b0;
      jtag_on_q <= 1'b0;
      ext_on_q  <= 1'b0;
    end else begin
      host_q    <= host_d;
      jtag_on_q <= jon_d;
      ext_on_q  <= ext_d;
    end
  end

  // R7
  ext_needs_jtag_chk: assert property (@(posedge clk) disable iff (rst)
    ext_on_q |-> jtag_on_q);

  // R6
  ext_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_on_q) |-> ($past(ext_cmd) && $past(jtag_on_q)));

  // R5
  host_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !host_q);

  // R1
  dedicated_forces_on_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_dedicated) && !$past(rst)) |-> jtag_on_q);

endmodule

// File: rtl/jpm_status_drv.sv
module jpm_status_drv #(
  parameter int N_STS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_STS-1:0] flag_hi,
  input  logic [N_STS-1:0] od_sel,
  output logic [N_STS-1:0] drv_out,
  output logic [N_STS-1:0] drv_oe
);
  import jpm_pkg::*;

  for (genvar g = 0; g < N_STS; g++) begin : g_sts
    logic     level_q;
    pin_drv_t drv;

    always_ff @(posedge clk) begin
      if (rst) level_q <= 1'b1;
      else     level_q <= ~flag_hi[g];
    end

    assign drv        = status_drive(level_q, od_sel[g]);
    assign drv_out[g] = drv.out;
    assign drv_oe[g]  = drv.oe;

    // R8
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (!od_sel[g] && $past(flag_hi[g]) && !$past(rst)) |-> !drv_out[g]);

    // R9
    od_release_chk: assert property (@(posedge clk) disable iff (rst)
      (od_sel[g] && !$past(flag_hi[g]) && !$past(rst)) |-> (!drv_oe[g] && !drv_out[g]));
  end

endmodule

// File: rtl/jpm_pad_mux.sv
module jpm_pad_mux #(
  parameter int NPINS    = 8,
  parameter int PIN_TMS  = 0,
  parameter int PIN_TCK  = 1,
  parameter int PIN_STAT = 3,
  parameter int PIN_ERR  = 4,
  parameter int PIN_TDI  = 5,
  parameter int PIN_TDO  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             jtag_on,
  input  logic             ext_on,
  input  logic [1:0]       sts_out,
  input  logic [1:0]       sts_oe,
  input  logic             prog_tdo,
  input  logic [NPINS-1:0] gpio_out,
  input  logic [NPINS-1:0] gpio_oe,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] gpio_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             prog_tms,
  output logic             prog_tck,
  output logic             prog_tdi
);

  assign gpio_in = pad_in;

  assign prog_tms = jtag_on ? pad_in[PIN_TMS] : 1'b1;
  assign prog_tck = jtag_on ? pad_in[PIN_TCK] : 1'b0;
  assign prog_tdi = jtag_on ? pad_in[PIN_TDI] : 1'b1;

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    if (p == PIN_TMS || p == PIN_TCK || p == PIN_TDI) begin : g_jin
      assign pad_out[p] = jtag_on ? 1'b0 : gpio_out[p];
      assign pad_oe[p]  = jtag_on ? 1'b0 : gpio_oe[p];
    end else if (p == PIN_TDO) begin : g_jout
      assign pad_out[p] = jtag_on ? prog_tdo : gpio_out[p];
      assign pad_oe[p]  = jtag_on | gpio_oe[p];
    end else if (p == PIN_STAT) begin : g_stat
      assign pad_out[p] = ext_on ? sts_out[0] : gpio_out[p];
      assign pad_oe[p]  = ext_on ? sts_oe[0]  : gpio_oe[p];
    end else if (p == PIN_ERR) begin : g_err
      assign pad_out[p] = ext_on ? sts_out[1] : gpio_out[p];
      assign pad_oe[p]  = ext_on ? sts_oe[1]  : gpio_oe[p];
    end else begin : g_gpio
      assign pad_out[p] = gpio_out[p];
      assign pad_oe[p]  = gpio_oe[p];
    end
  end

  // R2
  tdo_drive_chk: assert property (@(posedge clk) disable iff (rst)
    jtag_on |-> (pad_oe[PIN_TDO] && pad_out[PIN_TDO] == prog_tdo));

  // R2
  jtag_inputs_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    jtag_on |-> !(pad_oe[PIN_TMS] | pad_oe[PIN_TCK] | pad_oe[PIN_TDI]));

  // R3
  gpio_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !jtag_on |-> (pad_oe == gpio_oe && pad_out == gpio_out && prog_tms && !prog_tck));

endmodule

// File: rtl/jtag_pin_mux.sv
module jtag_pin_mux #(
  parameter int NPINS       = 8,
  parameter int HOST_W      = 8,
  parameter int HOST_EN_BIT = 0,
  parameter int PIN_TMS     = 0,
  parameter int PIN_TCK     = 1,
  parameter int PIN_STAT    = 3,
  parameter int PIN_ERR     = 4,
  parameter int PIN_TDI     = 5,
  parameter int PIN_TDO     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_blank,
  input  logic              cfg_dedicated,
  input  logic              pld_jtag_en,
  input  logic              host_we,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              ext_cmd,
  input  logic              stat_od,
  input  logic              err_od,
  input  logic              eng_busy,
  input  logic              eng_error,
  input  logic              prog_tdo,
  output logic              prog_tms,
  output logic              prog_tck,
  output logic              prog_tdi,
  input  logic [NPINS-1:0]  gpio_out,
  input  logic [NPINS-1:0]  gpio_oe,
  output logic [NPINS-1:0]  gpio_in,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  localparam int N_STS = 2;

  logic             jtag_on_q;
  logic             ext_on_q;
  logic [N_STS-1:0] sts_out;
  logic [N_STS-1:0] sts_oe;

  jpm_mode_ctrl #(
    .HOST_W      (HOST_W),
    .HOST_EN_BIT (HOST_EN_BIT)
  ) u_mode (
    .clk           (clk),
    .rst           (rst),
    .cfg_blank     (cfg_blank),
    .cfg_dedicated (cfg_dedicated),
    .pld_jtag_en   (pld_jtag_en),
    .host_we       (host_we),
    .host_wdata    (host_wdata),
    .ext_cmd       (ext_cmd),
    .jtag_on_q     (jtag_on_q),
    .ext_on_q      (ext_on_q)
  );

  jpm_status_drv #(
    .N_STS (N_STS)
  ) u_sts (
    .clk     (clk),
    .rst     (rst),
    .flag_hi ({eng_error, eng_busy}),
    .od_sel  ({err_od, stat_od}),
    .drv_out (sts_out),
    .drv_oe  (sts_oe)
  );

  jpm_pad_mux #(
    .NPINS    (NPINS),
    .PIN_TMS  (PIN_TMS),
    .PIN_TCK  (PIN_TCK),
    .PIN_STAT (PIN_STAT),
    .PIN_ERR  (PIN_ERR),
    .PIN_TDI  (PIN_TDI),
    .PIN_TDO  (PIN_TDO)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .jtag_on  (jtag_on_q),
    .ext_on   (ext_on_q),
    .sts_out  (sts_out),
    .sts_oe   (sts_oe),
    .prog_tdo (prog_tdo),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe),
    .pad_in   (pad_in),
    .gpio_in  (gpio_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .prog_tms (prog_tms),
    .prog_tck (prog_tck),
    .prog_tdi (prog_tdi)
  );

endmodule

// File: tb/tb_jtag_pin_mux.sv
module tb_jtag_pin_mux;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       cfg_blank = 0, cfg_dedicated = 0, pld_jtag_en = 0;
  logic       host_we = 0;
  logic [7:0] host_wdata = 0;
  logic       ext_cmd = 0, stat_od = 0, err_od = 0, eng_busy = 0, eng_error = 0, prog_tdo = 0;
  logic [7:0] gpio_out = 0, gpio_oe = 0, pad_in = 0;
  logic       prog_tms, prog_tck, prog_tdi;
  logic [7:0] gpio_in, pad_out, pad_oe;

  jtag_pin_mux dut (
    .clk(clk), .rst(rst), .cfg_blank(cfg_blank), .cfg_dedicated(cfg_dedicated),
    .pld_jtag_en(pld_jtag_en), .host_we(host_we), .host_wdata(host_wdata),
    .ext_cmd(ext_cmd), .stat_od(stat_od), .err_od(err_od), .eng_busy(eng_busy),
    .eng_error(eng_error), .prog_tdo(prog_tdo), .prog_tms(prog_tms),
    .prog_tck(prog_tck), .prog_tdi(prog_tdi), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .gpio_in(gpio_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model state
  logic m_host = 0, m_jon = 0, m_ext = 0, m_stat = 1, m_err = 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] sts_exp(input logic lvl, input logic od);
    return od ? {1'b0, ~lvl} : {lvl, 1'b1};
  endfunction

  task automatic model_next();
    logic h, j, e;
    if (rst) begin
      m_host = 0; m_jon = 0; m_ext = 0; m_stat = 1; m_err = 1;
    end else begin
      h = host_we ? host_wdata[0] : m_host;
      j = cfg_blank | cfg_dedicated | pld_jtag_en | h;
      e = j & (m_ext | (ext_cmd & m_jon));
      m_host = h; m_jon = j; m_ext = e;
      m_stat = ~eng_busy; m_err = ~eng_error;
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < 8; i++) begin
      logic [1:0] e;
      string r;
      e = {gpio_out[i], gpio_oe[i]};
      r = (i == 2 || i == 7) ? "R10" : "R3";
      if (m_jon && (i == 0 || i == 1 || i == 5)) begin e = 2'b00; r = "R2"; end
      else if (m_jon && i == 6) begin e = {prog_tdo, 1'b1}; r = "R2"; end
      else if (m_ext && i == 3) begin e = sts_exp(m_stat, stat_od); r = "R8 R9 stat"; end
      else if (m_ext && i == 4) begin e = sts_exp(m_err, err_od); r = "R8 R9 err"; end
      chk($sformatf("%s pad%0d {out,oe}", r, i), {6'b0, pad_out[i], pad_oe[i]}, {6'b0, e});
    end
    chk("R4 gpio_in", gpio_in, pad_in);
    chk(m_jon ? "R2 prog inputs" : "R3 prog idle", {5'b0, prog_tms, prog_tck, prog_tdi},
        m_jon ? {5'b0, pad_in[0], pad_in[1], pad_in[5]} : 8'b0000_0101);
  endtask

  task automatic step();
    model_next();
    @(negedge clk);
    check_all();
  endtask

  task automatic clear_in();
    rst = 0; cfg_blank = 0; cfg_dedicated = 0; pld_jtag_en = 0;
    host_we = 0; ext_cmd = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1;
    step(); step();
    chk("R3 reset pad_oe", pad_oe, gpio_oe);
    rst = 0;

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      rst = ($urandom % 300) == 0;
      if ($urandom % 64 == 0) cfg_blank = ~cfg_blank;
      if ($urandom % 48 == 0) cfg_dedicated = ~cfg_dedicated;
      if ($urandom % 12 == 0) pld_jtag_en = ~pld_jtag_en;
      host_we    = ($urandom % 10) == 0;
      host_wdata = 8'($urandom);
      ext_cmd    = ($urandom % 8) == 0;
      if ($urandom % 40 == 0) stat_od = ~stat_od;
      if ($urandom % 40 == 0) err_od = ~err_od;
      eng_busy  = ($urandom % 3) == 0;
      eng_error = ($urandom % 5) == 0;
      prog_tdo  = 1'($urandom);
      gpio_out  = 8'($urandom);
      gpio_oe   = 8'($urandom);
      pad_in    = 8'($urandom);
      step();
    end

    // Directed: command while inactive ignored (R6)
    clear_in(); rst = 1; step(); clear_in();
    gpio_oe = 8'h00; gpio_out = 8'h00; stat_od = 0; err_od = 0; eng_busy = 1; eng_error = 1;
    ext_cmd = 1; step();
    ext_cmd = 0; host_we = 1; host_wdata = 8'h01; step();
    host_we = 0; step();
    chk("R6 ignored cmd pad3 oe", {7'b0, pad_oe[3]}, 8'h00);
    chk("R6 ignored cmd pad4 oe", {7'b0, pad_oe[4]}, 8'h00);

    // Directed: command while active enables, then drop (R6, R7)
    ext_cmd = 1; step(); ext_cmd = 0;
    chk("R6 ext on pad3 oe", {7'b0, pad_oe[3]}, 8'h01);
    chk("R8 busy pad3 level", {7'b0, pad_out[3]}, 8'h00);
    host_we = 1; host_wdata = 8'h00; step(); host_we = 0;
    chk("R7 ext off with jtag pad3 oe", {7'b0, pad_oe[3]}, 8'h00);
    chk("R7 pad6 back to gpio", {7'b0, pad_oe[6]}, 8'h00);
    host_we = 1; host_wdata = 8'h01; step(); host_we = 0;
    chk("R7 ext stays off pad4 oe", {7'b0, pad_oe[4]}, 8'h00);

    // Directed: reset clears host bit (R5)
    pad_in = 8'h00; rst = 1; step(); rst = 0; step();
    chk("R5 host bit cleared prog_tms", {7'b0, prog_tms}, 8'h01);

    // Directed: each source alone (R1)
    pad_in = 8'h02; pld_jtag_en = 1; step();
    chk("R1 pld source prog_tck", {7'b0, prog_tck}, 8'h01);
    pld_jtag_en = 0; step();
    chk("R1 all off prog_tck", {7'b0, prog_tck}, 8'h00);
    cfg_blank = 1; step();
    chk("R1 blank source pad1 oe", {7'b0, pad_oe[1]}, 8'h00);

    // Directed: status latency and open drain (R8, R9)
    eng_busy = 0; eng_error = 0; ext_cmd = 1; step(); ext_cmd = 0;
    chk("R8 ready pad3 out", {7'b0, pad_out[3]}, 8'h01);
    eng_busy = 1; stat_od = 1; step();
    chk("R9 od busy pad3 {out,oe}", {6'b0, pad_out[3], pad_oe[3]}, 8'h01);
    eng_busy = 0; step();
    chk("R9 od ready pad3 {out,oe}", {6'b0, pad_out[3], pad_oe[3]}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule